// File: doc/BRIEF.md
# Key-Guarded Control Register Bank

This block holds a small set of 32-bit control words behind a word-addressed command port. Each word address belongs to one of four access classes: read-write, read-only, write-only, or unmapped. An access the class forbids is refused and reported on a one-cycle error output. A global guard bit protects the bank. While the guard is set, writes to the general bank and to the reset-control word are silently discarded. The guard is set or cleared only by writing a 16-bit key to one of two dedicated key addresses. It comes out of reset set, so software must unlock the bank before it can configure anything.

One scratch word sits outside the guard and keeps only its least significant bit. Writing a one to bit 0 of the reset-control word while the bank is open produces a single-cycle system reset request. Commands take one cycle and are never stalled. A read returns its data, with a valid strobe, in the cycle after the command is taken. The command port has no ready signal, so there is no back-pressure: the response strobe is not held and must be consumed when it appears.

Top module: `keyguard_regbank`

## Requirements
- R1: After reset the guard is set, the scratch word and the reset-control word read 0, and bank word i (word addresses 64..71) reads 32'h0001A008 + i*32'h00000104. rsp_valid, access_err and reset_req are low.
- R2: A write to word 1 (byte 0x004) whose bits [15:0] equal 16'h767B sets the guard. Bits [31:16] of that write have no effect on the outcome.
- R3: A write to word 2 (byte 0x008) whose bits [15:0] equal 16'hDF0D clears the guard.
- R4: A write to word 1 or word 2 with any other value in bits [15:0] leaves the guard unchanged and raises no error.
- R5: Word 3 (byte 0x00C) is read-only. It returns the guard in bit 0, with bits [31:1] at zero.
- R6: While the guard is set, writes to the bank words and to the reset-control word (word 128, byte 0x200) are discarded without an error. While it is clear, those writes store all 32 bits.
- R7: Word 0 stores only bit 0 of the written data, whatever the state of the guard. It reads back as {31'b0, bit}.
- R8: A write to word 128 with bit 0 set, while the guard is clear, drives reset_req high in exactly the following cycle. No pulse follows if the guard is set or if bit 0 is 0.
- R9: A read command gives rsp_valid high with rsp_rdata in the following cycle. A write command gives no response.
- R10: Words 1, 2, 160 and 161 are write-only. Words 3, 144 and 145 are read-only. Every other address outside words 0, 64..71 and 128 is unmapped. A read of a write-only or unmapped word returns 0. A write to a read-only or unmapped word is discarded. Each such access raises access_err for exactly the following cycle.
- R11: Word 144 reads the ID_CODE parameter (default 32'h1B3C0093). Word 145 reads the BOOT_VAL parameter (default 32'h00000005).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 32 | Read data |
| access_err | output | 1 | Refused access, one-cycle pulse |
| reset_req | output | 1 | System reset request, one-cycle pulse |

## Verification
Two events can fall in the same cycle. The first is the reset-request pulse from an accepted reset-control write. The second is a lock-key write issued directly behind it, which sets the guard at the same edge that shows the pulse. The bench issues the reset-control write and the lock write back-to-back. It then expects the pulse in exactly one cycle and no pulse from a repeat of the reset-control write. A second overlap is the error pulse appearing together with the read strobe on a refused read. The read sweeps over every address judge that case by requiring both outputs high and the data at zero.

// File: rtl/keyguard_pkg.sv
package keyguard_pkg;
  localparam int DATA_W = 32;
  localparam logic [15:0] LOCK_KEY   = 16'h767B;
  localparam logic [15:0] UNLOCK_KEY = 16'hDF0D;

  typedef enum logic [1:0] {ACC_NONE, ACC_RO, ACC_WO, ACC_RW} acc_e;

  typedef enum logic [3:0] {
    K_NONE, K_SCRATCH, K_LOCK, K_UNLOCK, K_STATUS,
    K_BANK, K_RSTCTL, K_ID, K_BOOT, K_START
  } kind_e;

  typedef struct packed {
    acc_e  acc;
    kind_e kind;
  } slot_t;

  typedef enum logic {ST_OPEN = 1'b0, ST_GUARDED = 1'b1} guard_e;
endpackage

// File: rtl/keyguard_decode.sv
module keyguard_decode
  import keyguard_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int BANK_BASE  = 64,
  parameter int BANK_N     = 8,
  parameter int RST_WORD   = 128,
  parameter int ID_WORD    = 144,
  parameter int BOOT_WORD  = 145,
  parameter int START_BASE = 160,
  parameter int START_N    = 2,
  parameter int IDX_W      = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output slot_t             slot,
  output logic [IDX_W-1:0]  idx
);
  int a;

  always_comb begin
    a = int'(addr);
    idx = IDX_W'(a - BANK_BASE);
    slot.acc  = ACC_NONE;
    slot.kind = K_NONE;
    if (a == 0) begin
      slot.acc = ACC_RW; slot.kind = K_SCRATCH;
    end else if (a == 1) begin
      slot.acc = ACC_WO; slot.kind = K_LOCK;
    end else if (a == 2) begin
      slot.acc = ACC_WO; slot.kind = K_UNLOCK;
    end else if (a == 3) begin
      slot.acc = ACC_RO; slot.kind = K_STATUS;
    end else if (a >= BANK_BASE && a < BANK_BASE + BANK_N) begin
      slot.acc = ACC_RW; slot.kind = K_BANK;
    end else if (a == RST_WORD) begin
      slot.acc = ACC_RW; slot.kind = K_RSTCTL;
    end else if (a == ID_WORD) begin
      slot.acc = ACC_RO; slot.kind = K_ID;
    end else if (a == BOOT_WORD) begin
      slot.acc = ACC_RO; slot.kind = K_BOOT;
    end else if (a >= START_BASE && a < START_BASE + START_N) begin
      slot.acc = ACC_WO; slot.kind = K_START;
    end
  end
endmodule

// File: rtl/keyguard_guard.sv
module keyguard_guard
  import keyguard_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lock,
  input  logic        wr_unlock,
  input  logic [15:0] key,
  output logic        guarded
);
  guard_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr_lock && key == LOCK_KEY)
      state_d = ST_GUARDED;
    else if (wr_unlock && key == UNLOCK_KEY)
      state_d = ST_OPEN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_GUARDED;
    else        state_q <= state_d;
  end

  assign guarded = (state_q == ST_GUARDED);
endmodule

// File: rtl/keyguard_store.sv
module keyguard_store
  import keyguard_pkg::*;
#(
  parameter int          BANK_N    = 8,
  parameter int          IDX_W     = 3,
  parameter logic [31:0] BANK_SEED = 32'h0001_A008,
  parameter logic [31:0] BANK_STEP = 32'h0000_0104
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [IDX_W-1:0]              idx,
  input  logic [DATA_W-1:0]             wdata,
  output logic [BANK_N-1:0][DATA_W-1:0] bank_q
);
  for (genvar i = 0; i < BANK_N; i++) begin : g_word
    localparam logic [31:0] RSTV = BANK_SEED + 32'(i) * BANK_STEP;
    always_ff @(posedge clk) begin
      if (!rst_n)
        bank_q[i] <= RSTV;
      else if (we && idx == IDX_W'(i))
        bank_q[i] <= wdata;
    end
  end
endmodule

// File: rtl/keyguard_regbank.sv
module keyguard_regbank
  import keyguard_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          BANK_BASE  = 64,
  parameter int          BANK_N     = 8,
  parameter int          RST_WORD   = 128,
  parameter int          ID_WORD    = 144,
  parameter int          BOOT_WORD  = 145,
  parameter int          START_BASE = 160,
  parameter int          START_N    = 2,
  parameter logic [31:0] BANK_SEED  = 32'h0001_A008,
  parameter logic [31:0] BANK_STEP  = 32'h0000_0104,
  parameter logic [31:0] ID_CODE    = 32'h1B3C_0093,
  parameter logic [31:0] BOOT_VAL   = 32'h0000_0005
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [31:0]       cmd_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              access_err,
  output logic              reset_req
);
  localparam int IDX_W = (BANK_N > 1) ? $clog2(BANK_N) : 1;

  slot_t                        slot;
  logic [IDX_W-1:0]             bank_idx;
  logic [BANK_N-1:0][DATA_W-1:0] bank_q;
  logic                         guarded;
  logic                         scr_q;
  logic [DATA_W-1:0]            rstctl_q;
  logic [DATA_W-1:0]            rmux;
  logic                         is_wr, is_rd, illegal, legal_wr;
  logic                         bank_we, rst_we, scr_we;

  keyguard_decode #(
    .ADDR_W(ADDR_W), .BANK_BASE(BANK_BASE), .BANK_N(BANK_N),
    .RST_WORD(RST_WORD), .ID_WORD(ID_WORD), .BOOT_WORD(BOOT_WORD),
    .START_BASE(START_BASE), .START_N(START_N), .IDX_W(IDX_W)
  ) u_dec (
    .addr(cmd_addr), .slot(slot), .idx(bank_idx)
  );

  assign is_wr   = cmd_valid && cmd_write;
  assign is_rd   = cmd_valid && !cmd_write;
  assign illegal = cmd_valid && ((slot.acc == ACC_NONE) ||
                                 (cmd_write  && slot.acc == ACC_RO) ||
                                 (!cmd_write && slot.acc == ACC_WO));
  assign legal_wr = is_wr && !illegal;
  assign bank_we  = legal_wr && slot.kind == K_BANK   && !guarded;
  assign rst_we   = legal_wr && slot.kind == K_RSTCTL && !guarded;
  assign scr_we   = legal_wr && slot.kind == K_SCRATCH;

  keyguard_guard u_guard (
    .clk(clk), .rst_n(rst_n),
    .wr_lock(legal_wr && slot.kind == K_LOCK),
    .wr_unlock(legal_wr && slot.kind == K_UNLOCK),
    .key(cmd_wdata[15:0]),
    .guarded(guarded)
  );

  keyguard_store #(
    .BANK_N(BANK_N), .IDX_W(IDX_W),
    .BANK_SEED(BANK_SEED), .BANK_STEP(BANK_STEP)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .idx(bank_idx),
    .wdata(cmd_wdata), .bank_q(bank_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scr_q    <= 1'b0;
      rstctl_q <= '0;
    end else begin
      if (scr_we) scr_q    <= cmd_wdata[0];
      if (rst_we) rstctl_q <= cmd_wdata;
    end
  end

  always_comb begin
    unique case (slot.kind)
      K_SCRATCH: rmux = {31'b0, scr_q};
      K_STATUS:  rmux = {31'b0, guarded};
      K_BANK:    rmux = bank_q[bank_idx];
      K_RSTCTL:  rmux = rstctl_q;
      K_ID:      rmux = ID_CODE;
      K_BOOT:    rmux = BOOT_VAL;
      default:   rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      access_err <= 1'b0;
      reset_req  <= 1'b0;
    end else begin
      rsp_valid  <= is_rd;
      rsp_rdata  <= (is_rd && !illegal) ? rmux : '0;
      access_err <= illegal;
      reset_req  <= rst_we && cmd_wdata[0];
    end
  end
endmodule

// File: rtl/keyguard_regbank_chk.sv
module keyguard_regbank_chk
  import keyguard_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int RST_WORD = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_write,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [31:0]       cmd_wdata,
  input logic              rsp_valid,
  input logic              access_err,
  input logic              reset_req,
  input logic              guarded
);
  logic wr_key_lock, wr_key_unlock;
  assign wr_key_lock   = cmd_valid && cmd_write && cmd_addr == ADDR_W'(1);
  assign wr_key_unlock = cmd_valid && cmd_write && cmd_addr == ADDR_W'(2);

  p_lock_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_key_lock && cmd_wdata[15:0] == LOCK_KEY) |=> guarded);

  p_unlock_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_key_unlock && cmd_wdata[15:0] == UNLOCK_KEY) |=> !guarded);

  p_bad_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_key_lock && cmd_wdata[15:0] != LOCK_KEY) ||
     (wr_key_unlock && cmd_wdata[15:0] != UNLOCK_KEY)) |=> $stable(guarded));

  p_req_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(cmd_valid && cmd_write && cmd_addr == ADDR_W'(RST_WORD)
                        && cmd_wdata[0] && !guarded));

  p_rsp_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd_valid && !cmd_write));

  p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    access_err |-> $past(cmd_valid));
endmodule

bind keyguard_regbank keyguard_regbank_chk #(
  .ADDR_W(ADDR_W), .RST_WORD(RST_WORD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
  .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
  .access_err(access_err), .reset_req(reset_req), .guarded(guarded)
);

// File: tb/sim_keyguard_regbank.sv
`timescale 1ns/1ps
module sim_keyguard_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_write = 1'b0;
  logic [7:0]  cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic        rsp_valid, access_err, reset_req;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;

  logic        m_lock, m_scr;
  logic [31:0] m_bank [8];
  logic [31:0] m_rst;

  logic        o_rv, o_err, o_req;
  logic [31:0] o_rd;

  always #2 clk = ~clk;

  keyguard_regbank u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .access_err(access_err), .reset_req(reset_req)
  );

  // 0 unmapped, 1 read-only, 2 write-only, 3 read-write
  function automatic int cls(int a);
    if (a == 0 || (a >= 64 && a < 72) || a == 128) return 3;
    if (a == 1 || a == 2 || a == 160 || a == 161) return 2;
    if (a == 3 || a == 144 || a == 145) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] exp_rd(int a);
    if (a == 0) return {31'b0, m_scr};
    if (a == 3) return {31'b0, m_lock};
    if (a >= 64 && a < 72) return m_bank[a-64];
    if (a == 128) return m_rst;
    if (a == 144) return 32'h1B3C_0093;
    if (a == 145) return 32'h0000_0005;
    return 32'h0;
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmd(input bit w, input int a, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = w; cmd_addr = 8'(a); cmd_wdata = d;
    @(posedge clk);
    #1;
    o_rv = rsp_valid; o_err = access_err; o_req = reset_req; o_rd = rsp_rdata;
    cmd_valid = 1'b0;
  endtask

  task automatic do_read(input int a, input string req);
    cmd(1'b0, a, 32'h0);
    chk("R9 rsp_valid", {31'b0, o_rv}, 32'd1);
    chk(req, o_rd, exp_rd(a));
    chk("R10 read err", {31'b0, o_err}, {31'b0, (cls(a) == 0 || cls(a) == 2)});
  endtask

  task automatic do_write(input int a, input logic [31:0] d);
    logic req_exp;
    req_exp = (cls(a) == 3 && a == 128 && !m_lock && d[0]);
    cmd(1'b1, a, d);
    chk("R10 write err", {31'b0, o_err}, {31'b0, (cls(a) == 0 || cls(a) == 1)});
    chk("R9 no rsp on write", {31'b0, o_rv}, 32'd0);
    chk("R8 reset_req", {31'b0, o_req}, {31'b0, req_exp});
    if (cls(a) >= 2) begin
      if (a == 0) m_scr = d[0];
      else if (a == 1 && d[15:0] == 16'h767B) m_lock = 1'b1;
      else if (a == 2 && d[15:0] == 16'hDF0D) m_lock = 1'b0;
      else if (a >= 64 && a < 72 && !m_lock) m_bank[a-64] = d;
      else if (a == 128 && !m_lock) m_rst = d;
    end
  endtask

  task automatic read_sweep(input string req);
    for (int a = 0; a < 256; a++) do_read(a, req);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    m_lock = 1'b1; m_scr = 1'b0; m_rst = 32'h0;
    for (int i = 0; i < 8; i++) m_bank[i] = 32'h0001_A008 + 32'(i) * 32'h0000_0104;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 outputs idle", {29'b0, rsp_valid, access_err, reset_req}, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    read_sweep("R1 reset read");
    do_read(3, "R5 status locked");
    do_read(144, "R11 id");
    do_read(145, "R11 boot");

    // locked sweep: bank and reset-control writes dropped (R6)
    for (int a = 0; a < 256; a++)
      do_write(a, {~8'(a), 8'(a), 8'(a) ^ 8'h5A, 8'(a)});
    read_sweep("R6 locked readback");

    // wrong keys (R4)
    do_write(2, 32'h0000_DF0C);
    do_write(2, 32'h0000_767B);
    do_read(3, "R4 wrong key keeps lock");
    do_write(2, 32'h1234_DF0D);
    do_read(3, "R3 unlock");
    do_write(1, 32'h0000_767C);
    do_read(3, "R4 wrong lock key");
    do_write(1, 32'hABCD_767B);
    do_read(3, "R2 lock with upper bits");
    do_write(2, 32'h0000_DF0D);
    do_read(3, "R3 unlock again");

    // open sweep: writes land (R6, R7, R8)
    for (int a = 3; a < 256; a++)
      do_write(a, {8'(a) ^ 8'hC3, 8'(a), 8'(a), 8'(a) + 8'h11});
    read_sweep("R6 open readback");

    // scratch keeps bit 0 regardless of lock (R7)
    do_write(0, 32'hFFFF_FFFE);
    do_read(0, "R7 scratch bit0 zero");
    do_write(0, 32'h8000_0001);
    do_read(0, "R7 scratch bit0 one");

    // reset request with bit 0 clear, then set (R8)
    do_write(128, 32'h0000_0002);
    do_write(128, 32'h0000_0003);
    do_read(128, "R6 rstctl stored");

    // back-to-back: reset request then lock, then request again (R8, R2)
    do_write(128, 32'h0000_0001);
    do_write(1, 32'h0000_767B);
    do_write(128, 32'h0000_0001);
    do_read(3, "R2 lock after pulse");
    do_write(0, 32'h0000_0000);
    do_read(0, "R7 scratch writable while locked");
    chk("R8 pulse ended", {31'b0, reset_req}, 32'd0);

    summary();
    $finish;
  end
endmodule